// File: doc/BRIEF.md
# Rotating Banked Shared-Memory Scheduler

This block gives sixteen client cores shared access to one word-wide memory without any priority arbitration. The memory is cut into sixteen banks, and the bank that holds a word is chosen by the four lowest bits of its word address. A free-running rotation counter links every client to a different bank in every clock. Over sixteen clocks each client meets every bank once, so two clients never contend for a bank. How long an access waits depends only on where the target bank sits in the rotation when the request arrives. A client can predict that wait, and the block behaves the same way every time.

Each client has two ways in. The single-word port carries one read or one write under a request/ready handshake. The burst port moves a run of consecutive word addresses. It starts at whichever bank the client faces at that moment and fills the words in the order the banks come round, so a full run of sixteen words takes sixteen clocks.

Top module: `hub_rot_arbiter`

## Requirements
- R1: After reset, `sp_ready`, `bu_done` and `bu_rvalid` are low for every client.
- R2: The rotation value resets to 0 and steps by one every clock. In a given clock, client c is linked to bank (c + rotation) mod 16, and bank = word address bits [3:0].
- R3: A single read accepted at clock edge E raises `sp_ready` for exactly one clock after edge E+4+w. Here w = (bank − c − rotation in the clock after E) mod 16, so a read that meets its bank at once completes in 5 clocks.
- R4: A single write raises `sp_ready` for exactly one clock after edge E+2+w, with w defined as in R3.
- R5: While `sp_ready` is high after a read, `sp_rdata` holds the word most recently written to that address by any client or by any burst.
- R6: When `sp_req` stays high and the address moves to a new one the clock `sp_ready` is seen, reads 16 words apart produce `sp_ready` pulses 16 clocks apart.
- R7: Under the same chaining, reads of consecutive word addresses produce pulses 17 clocks apart.
- R8: Under the same chaining, reads two word addresses apart produce pulses 18 clocks apart.
- R9: A burst of length L (1 to 16) from base B serves, in clock j after acceptance, the offset (c + rotation − B) mod 16 when that offset is below L. `bu_done` pulses one clock after the clock that serves the last offset, so a burst of 16 finishes within 16 clocks.
- R10: A burst read raises `bu_rvalid` exactly L times, each offset below L once. It presents offset `bu_ridx` with the data of word B + offset in the same clock.
- R11: A burst write stores at word B + offset the value on `bu_wdata` that the client drives while `bu_widx` shows that offset.
- R12: All sixteen clients can carry single requests at the same time, and each one completes with its own latency under R3 and its own correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sp_req | input | 16 | Single-word request, one per client |
| sp_we | input | 16 | Single-word write select (1 = write) |
| sp_addr | input | 16×10 | Single-word word address |
| sp_wdata | input | 16×32 | Single-word write data |
| sp_ready | output | 16 | One-clock completion pulse |
| sp_rdata | output | 16×32 | Single-word read data, valid with `sp_ready` |
| bu_go | input | 16 | Burst start |
| bu_we | input | 16 | Burst write select (1 = write) |
| bu_base | input | 16×10 | Burst base word address, held stable during the burst |
| bu_len | input | 16×5 | Burst length, 1 to 16 |
| bu_widx | output | 16×4 | Burst offset served this clock, used to supply write data |
| bu_wdata | input | 16×32 | Burst write data for offset `bu_widx` |
| bu_rvalid | output | 16 | Burst read data valid |
| bu_ridx | output | 16×4 | Offset of the burst read word presented |
| bu_rdata | output | 16×32 | Burst read data |
| bu_done | output | 16 | One-clock burst completion pulse |

## Verification
Single reads and writes are issued from several clients and at several rotation phases. Each latency is compared with the wait predicted from the bench's own rotation count. A case built so that the bank is met immediately checks the 5-clock read floor.

Chained reads at strides of 16, 1 and 2 words give ready spacings of 16, 17 and 18 clocks. These three spacings can only come out that way if the rotation and the fixed pipeline both match the model.

Bursts are run as full-length, as short, and from unaligned bases. This separates correct wrap-around offset selection from a design that simply counts words in order. All sixteen clients are then loaded at once to show that bank access has no cross-client interference.

// File: rtl/hub_pkg.sv
// Shared types for the rotating banked memory scheduler.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package hub_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PIPE,
        ST_DONE,
        ST_BURST,
        ST_BEND
    } port_st_t;

endpackage

// File: rtl/hub_bank.sv
// One memory bank: synchronous single-port RAM with one access per clock.
// Assumes the rotation guarantees at most one client drives it per clock.
// Read data is registered and holds until the next read.
module hub_bank #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int BAW  = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           en,
    input  logic           we,
    input  logic [BAW-1:0] addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Perform the single write or read for this clock
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end else if (en) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/hub_port.sv
// Per-client access engine. It serves one single-word request or one
// burst at a time, using the bank the client faces in the current clock.
// Assumes NCLI is a power of two, the burst length lies in 1..NCLI and
// the burst base is held stable until done.
module hub_port
    import hub_pkg::*;
#(
    parameter int NCLI = 16,
    parameter int AW   = 10,
    parameter int DW   = 32,
    parameter int CID  = 0,
    localparam int IW  = $clog2(NCLI),
    localparam int LW  = IW + 1,
    localparam int BAW = AW - IW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IW-1:0]            rot,
    input  logic                     req,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    output logic                     ready,
    output logic [DW-1:0]            rdata,
    input  logic                     bgo,
    input  logic                     bwe,
    input  logic [AW-1:0]            bbase,
    input  logic [LW-1:0]            blen,
    output logic [IW-1:0]            widx,
    input  logic [DW-1:0]            bwdata,
    output logic                     rvalid,
    output logic [IW-1:0]            ridx,
    output logic [DW-1:0]            brdata,
    output logic                     done,
    input  logic [NCLI-1:0][DW-1:0]  bank_rdata,
    output logic                     mem_en,
    output logic                     mem_we,
    output logic [BAW-1:0]           mem_addr,
    output logic [DW-1:0]            mem_wdata
);

    port_st_t      st;
    logic [AW-1:0] a_q, bb_q, baddr;
    logic          w_q, bw_q, cap_q, rv_q;
    logic [DW-1:0] d_q, rd_q;
    logic [LW-1:0] bl_q, cnt_q;
    logic [IW-1:0] facing, off, ridx_q, rbank_q;
    logic          slot, hit, can_start;

    // Work out which bank is faced now and whether it serves a pending access
    always_comb begin
        facing    = IW'(CID) + rot;
        off       = facing - bb_q[IW-1:0];
        baddr     = bb_q + AW'(off);
        slot      = (st == ST_WAIT) && (facing == a_q[IW-1:0]);
        hit       = (st == ST_BURST) && ({1'b0, off} < bl_q);
        can_start = (st == ST_IDLE) || (st == ST_DONE) || (st == ST_BEND);
    end

    // Drive the bank-side request for this clock
    always_comb begin
        mem_en    = slot || hit;
        mem_we    = slot ? w_q : bw_q;
        mem_addr  = slot ? a_q[AW-1:IW] : baddr[AW-1:IW];
        mem_wdata = slot ? d_q : bwdata;
    end

    // Present results to the client
    always_comb begin
        ready  = (st == ST_DONE);
        rdata  = rd_q;
        done   = (st == ST_BEND);
        widx   = off;
        rvalid = rv_q;
        ridx   = ridx_q;
        brdata = bank_rdata[rbank_q];
    end

    // Sequence single and burst accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            a_q     <= '0;
            w_q     <= 1'b0;
            d_q     <= '0;
            bb_q    <= '0;
            bl_q    <= '0;
            bw_q    <= 1'b0;
            cnt_q   <= '0;
            cap_q   <= 1'b0;
            rd_q    <= '0;
            rv_q    <= 1'b0;
            ridx_q  <= '0;
            rbank_q <= '0;
        end else begin
            rv_q    <= hit && !bw_q;
            ridx_q  <= off;
            rbank_q <= facing;
            cap_q   <= 1'b0;
            if (cap_q) begin
                rd_q <= bank_rdata[a_q[IW-1:0]];
            end
            if (can_start) begin
                if (bgo) begin
                    st    <= ST_BURST;
                    bb_q  <= bbase;
                    bl_q  <= blen;
                    bw_q  <= bwe;
                    cnt_q <= '0;
                end else if (req) begin
                    st  <= ST_WAIT;
                    a_q <= addr;
                    w_q <= we;
                    d_q <= wdata;
                end else begin
                    st <= ST_IDLE;
                end
            end else begin
                case (st)
                    ST_WAIT: begin
                        if (slot) begin
                            st    <= ST_PIPE;
                            cnt_q <= w_q ? LW'(0) : LW'(2);
                            cap_q <= !w_q;
                        end
                    end
                    ST_PIPE: begin
                        if (cnt_q == '0) begin
                            st <= ST_DONE;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    ST_BURST: begin
                        if (hit) begin
                            cnt_q <= cnt_q + 1'b1;
                            if (cnt_q == bl_q - 1'b1) begin
                                st <= ST_BEND;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // Count clocks spent in a burst for the bound check
    logic [LW-1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n || st != ST_BURST) begin
            age_q <= '0;
        end else begin
            age_q <= age_q + 1'b1;
        end
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);                                          // R3
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && !w_q) |-> ##4 ready);                              // R3
    AST_WR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && w_q) |-> ##2 ready);                               // R4
    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BURST) |-> (age_q < LW'(NCLI)));                  // R9

endmodule

// File: rtl/hub_rot_arbiter.sv
// Top level: rotation counter, one access engine per client, one bank per
// rotation slot, and a crossbar that links bank b to client (b - rot).
// Assumes NCLI is a power of two and AW > log2(NCLI).
module hub_rot_arbiter #(
    parameter int NCLI = 16,
    parameter int AW   = 10,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NCLI),
    localparam int LW  = IW + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCLI-1:0]          sp_req,
    input  logic [NCLI-1:0]          sp_we,
    input  logic [NCLI-1:0][AW-1:0]  sp_addr,
    input  logic [NCLI-1:0][DW-1:0]  sp_wdata,
    output logic [NCLI-1:0]          sp_ready,
    output logic [NCLI-1:0][DW-1:0]  sp_rdata,
    input  logic [NCLI-1:0]          bu_go,
    input  logic [NCLI-1:0]          bu_we,
    input  logic [NCLI-1:0][AW-1:0]  bu_base,
    input  logic [NCLI-1:0][LW-1:0]  bu_len,
    output logic [NCLI-1:0][IW-1:0]  bu_widx,
    input  logic [NCLI-1:0][DW-1:0]  bu_wdata,
    output logic [NCLI-1:0]          bu_rvalid,
    output logic [NCLI-1:0][IW-1:0]  bu_ridx,
    output logic [NCLI-1:0][DW-1:0]  bu_rdata,
    output logic [NCLI-1:0]          bu_done
);

    localparam int BAW   = AW - IW;
    localparam int DEPTH = 1 << BAW;

    logic [IW-1:0]             rot;
    logic [NCLI-1:0]           p_en, p_we;
    logic [NCLI-1:0][BAW-1:0]  p_addr;
    logic [NCLI-1:0][DW-1:0]   p_wd;
    logic [NCLI-1:0][DW-1:0]   bk_rd;

    // Advance the free-running rotation once per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot <= '0;
        end else begin
            rot <= rot + 1'b1;
        end
    end

    AST_ROT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (rot == $past(rot) + 1'b1));                      // R2

    for (genvar c = 0; c < NCLI; c++) begin : g_port
        hub_port #(
            .NCLI (NCLI),
            .AW   (AW),
            .DW   (DW),
            .CID  (c)
        ) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .rot        (rot),
            .req        (sp_req[c]),
            .we         (sp_we[c]),
            .addr       (sp_addr[c]),
            .wdata      (sp_wdata[c]),
            .ready      (sp_ready[c]),
            .rdata      (sp_rdata[c]),
            .bgo        (bu_go[c]),
            .bwe        (bu_we[c]),
            .bbase      (bu_base[c]),
            .blen       (bu_len[c]),
            .widx       (bu_widx[c]),
            .bwdata     (bu_wdata[c]),
            .rvalid     (bu_rvalid[c]),
            .ridx       (bu_ridx[c]),
            .brdata     (bu_rdata[c]),
            .done       (bu_done[c]),
            .bank_rdata (bk_rd),
            .mem_en     (p_en[c]),
            .mem_we     (p_we[c]),
            .mem_addr   (p_addr[c]),
            .mem_wdata  (p_wd[c])
        );
    end

    for (genvar b = 0; b < NCLI; b++) begin : g_bank
        logic [IW-1:0] sel;

        // Pick the one client that faces this bank in the current clock
        always_comb begin
            sel = IW'(b) - rot;
        end

        hub_bank #(
            .DW    (DW),
            .DEPTH (DEPTH)
        ) u_bank (
            .clk   (clk),
            .en    (p_en[sel]),
            .we    (p_we[sel]),
            .addr  (p_addr[sel]),
            .wdata (p_wd[sel]),
            .rdata (bk_rd[b])
        );
    end

endmodule

// File: tb/hub_rot_arbiter_bench.sv
// Directed bench: one task per scenario, each checking its own results
// against a bench-side rotation count and memory model.
module hub_rot_arbiter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int IW = 4;
    localparam int LW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]          sp_req = '0, sp_we = '0, sp_ready;
    logic [N-1:0][AW-1:0]  sp_addr = '0;
    logic [N-1:0][DW-1:0]  sp_wdata = '0, sp_rdata;
    logic [N-1:0]          bu_go = '0, bu_we = '0, bu_rvalid, bu_done;
    logic [N-1:0][AW-1:0]  bu_base = '0;
    logic [N-1:0][LW-1:0]  bu_len = '0;
    logic [N-1:0][IW-1:0]  bu_widx, bu_ridx;
    logic [N-1:0][DW-1:0]  bu_wdata, bu_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int tb_cnt = 0;
    logic [DW-1:0] model [1024];

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Bench copy of the rotation: clocks since reset release
    always @(posedge clk) if (rst_n) tb_cnt <= tb_cnt + 1;

    hub_rot_arbiter #(.NCLI(N), .AW(AW), .DW(DW)) u_hub_rot_arbiter (
        .clk(clk), .rst_n(rst_n),
        .sp_req(sp_req), .sp_we(sp_we), .sp_addr(sp_addr), .sp_wdata(sp_wdata),
        .sp_ready(sp_ready), .sp_rdata(sp_rdata),
        .bu_go(bu_go), .bu_we(bu_we), .bu_base(bu_base), .bu_len(bu_len),
        .bu_widx(bu_widx), .bu_wdata(bu_wdata), .bu_rvalid(bu_rvalid),
        .bu_ridx(bu_ridx), .bu_rdata(bu_rdata), .bu_done(bu_done)
    );

    function automatic logic [DW-1:0] pat(input int c, input int a);
        logic [9:0] a10;
        a10 = 10'(a);
        return {8'hA5, 4'(c), a10, ~a10};
    endfunction

    // Burst write data follows the offset the design is serving
    always_comb begin
        for (int c = 0; c < N; c++) begin
            bu_wdata[c] = pat(c, (int'(bu_base[c]) + int'(bu_widx[c])) % 1024);
        end
    end

    task automatic chk(input bit ok, input string rq,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic t_reset();
        chk(sp_ready == '0, "R1 ready after reset", 64'(sp_ready), 0);
        chk(bu_done == '0, "R1 done after reset", 64'(bu_done), 0);
        chk(bu_rvalid == '0, "R1 rvalid after reset", 64'(bu_rvalid), 0);
    endtask

    // One single access; latency per R3/R4, read data per R5
    task automatic t_single(input int c, input int a, input bit wr,
                            input logic [DW-1:0] d, input bit keep,
                            output int t_ready);
        int r, w, n, lat;
        sp_req[c]   = 1'b1;
        sp_we[c]    = wr;
        sp_addr[c]  = AW'(a);
        sp_wdata[c] = d;
        r   = tb_cnt % 16;
        w   = ((a % 16) - c - r - 1 + 48) % 16;
        lat = wr ? 3 + w : 5 + w;
        n   = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sp_ready[c] && n < 64);
        t_ready = tb_cnt;
        if (!keep) sp_req[c] = 1'b0;
        if (wr) begin
            chk(n == lat, "R4 write latency", 64'(n), 64'(lat));
            model[a] = d;
        end else begin
            chk(n == lat, "R3 read latency", 64'(n), 64'(lat));
            chk(sp_rdata[c] === model[a], "R5 read data", sp_rdata[c], model[a]);
        end
    endtask

    // One burst; completion per R9, read words per R10, writes per R11
    task automatic t_burst(input int c, input int base, input int len, input bit wr);
        int r, hits, kexp, kdone, nval;
        bit seen [16];
        foreach (seen[i]) seen[i] = 1'b0;
        bu_go[c]   = 1'b1;
        bu_we[c]   = wr;
        bu_base[c] = AW'(base);
        bu_len[c]  = LW'(len);
        r    = tb_cnt % 16;
        hits = 0;
        kexp = 0;
        for (int j = 1; j <= 32 && kexp == 0; j++) begin
            int off;
            off = (c + r + j - (base % 16) + 16) % 16;
            if (off < len) hits++;
            if (hits == len) kexp = j;
        end
        kdone = 0;
        nval  = 0;
        for (int j = 1; j <= 40 && kdone == 0; j++) begin
            @(negedge clk);
            bu_go[c] = 1'b0;
            if (bu_rvalid[c]) begin
                int ix, ad;
                ix = int'(bu_ridx[c]);
                ad = (base + ix) % 1024;
                nval++;
                chk(!wr && ix < len && !seen[ix], "R10 burst offset", 64'(ix), 64'(len));
                seen[ix] = 1'b1;
                chk(bu_rdata[c] === model[ad], "R10 burst data", bu_rdata[c], model[ad]);
            end
            if (bu_done[c]) kdone = j;
        end
        chk(kdone == kexp + 1, "R9 burst done cycle", 64'(kdone), 64'(kexp + 1));
        chk(nval == (wr ? 0 : len), "R10 burst word count", 64'(nval), 64'(wr ? 0 : len));
        if (wr) begin
            for (int i = 0; i < len; i++) model[(base + i) % 1024] = pat(c, (base + i) % 1024);
        end
    endtask

    // R11: written bursts read back through single reads
    task automatic t_burst_readback();
        int t;
        for (int a = 0; a < 64; a += 7) t_single(10, a, 1'b0, '0, 1'b0, t);
    endtask

    // R3: address chosen so the bank is met immediately
    task automatic t_fastest(input int c);
        int r, a, t0, t1;
        @(negedge clk);
        r  = tb_cnt % 16;
        a  = 16 + ((c + r + 1) % 16);
        t0 = tb_cnt;
        t_single(c, a, 1'b0, '0, 1'b0, t1);
        chk(t1 - t0 == 5, "R3 fastest read", 64'(t1 - t0), 5);
    endtask

    // R6/R7/R8: chained reads keep req high across the ready pulse
    task automatic t_spacing(input int a, input int stride, input int gap, input string rq);
        int t1, t2;
        @(negedge clk);
        t_single(5, a, 1'b0, '0, 1'b1, t1);
        t_single(5, a + stride, 1'b0, '0, 1'b0, t2);
        chk(t2 - t1 == gap, rq, 64'(t2 - t1), 64'(gap));
    endtask

    // R12: all clients at once
    task automatic t_all_clients();
        @(negedge clk);
        for (int c = 0; c < N; c++) begin
            automatic int cc = c;
            fork
                begin
                    int t;
                    t_single(cc, (cc * 5) % 64, 1'b0, '0, 1'b0, t);
                end
            join_none
        end
        wait fork;
        chk(sp_req == '0, "R12 all clients finished", 64'(sp_req), 0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_burst(2, 0, 16, 1'b1);
        t_burst(7, 16, 16, 1'b1);
        t_burst(9, 37, 11, 1'b1);
        t_burst(9, 32, 5, 1'b1);
        t_burst(4, 48, 16, 1'b1);
        t_burst_readback();
        t_burst(11, 0, 16, 1'b0);
        t_burst(1, 40, 5, 1'b0);
        t_burst(15, 61, 3, 1'b0);
        t_burst(0, 7, 1, 1'b0);
        t_single(3, 100, 1'b1, 32'hCAFE_0100, 1'b0, t);
        t_single(6, 100, 1'b0, '0, 1'b0, t);
        t_single(12, 100, 1'b1, 32'h1234_5678, 1'b0, t);
        t_single(3, 100, 1'b0, '0, 1'b0, t);
        t_fastest(0);
        t_fastest(13);
        t_spacing(3, 16, 16, "R6 same-bank spacing");
        t_spacing(20, 1, 17, "R7 consecutive spacing");
        t_spacing(30, 2, 18, "R8 every-second spacing");
        t_all_clients();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule